// File: doc/BRIEF.md
# Temperature Alarm with Fault Queue

This block watches signed temperature samples, one per completed conversion. It keeps two sticky status flags: one for over-temperature and one for under-temperature. It also drives a single alarm level whose active sense is chosen by an input. Samples and all four thresholds are 16-bit two's-complement numbers in units of 1/16 °C. Each direction has two thresholds: a set threshold and a hysteresis threshold, so a flag raised at one level is released or re-armed at the other.

A flag is raised only after a run of consecutive qualifying samples. The run length is chosen among 1, 2, 4 and 8. Each direction counts its own run.

The block has two modes. In comparator mode a flag follows the temperature with hysteresis. In interrupt mode a flag latches on an event and is cleared by a status-read strobe. After each event, the block watches for the opposite crossing. Shutdown clears all state at once. The package carries the customary power-on threshold constants for the register block that feeds the thresholds:

| Threshold | Value | Count in 1/16 °C |
|---|---|---|
| High | +100 °C | 1600 |
| High hysteresis | +90 °C | 1440 |
| Low | -40 °C | -640 |
| Low hysteresis | -30 °C | -480 |

Top module: `temp_alarm`

## Requirements
- R1: While `rst` is high, and on the first cycle after reset, `ot_flag` and `ut_flag` are 0 and `alarm_out` sits at its inactive level, which is the inverse of `alarm_pol`.
- R2: Comparator mode (`int_mode`=0), over-temperature direction:
  - A sample strictly greater than `hi_set` is a fault.
  - `ot_flag` rises on the clock edge that takes the qualifying sample.
  - A sample strictly below `hi_clr` clears `ot_flag` on its edge. No fault run is needed to clear.
  - A sample equal to either threshold changes nothing.
- R3: Comparator mode, under-temperature direction:
  - A sample strictly less than `lo_set` is a fault that raises `ut_flag`.
  - A sample strictly greater than `lo_clr` clears `ut_flag`.
  - Equality changes nothing.
- R4: Fault queue depth:
  - The run length is 2 to the power `fq_sel`: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
  - A flag rises only on the sample that completes the run.
  - Any valid non-qualifying sample restarts the run from zero.
  - The over and under directions keep separate counts.
- R5: Interrupt mode (`int_mode`=1), over-temperature direction:
  - A qualifying run above `hi_set` sets `ot_flag`.
  - The flag stays set until a `stat_rd` pulse clears it on that edge.
  - Samples arriving while the flag is set are not evaluated.
  - Each event swaps the watched crossing. After the first event the next one needs a run strictly below `hi_clr`, then strictly above `hi_set` again, and so on.
- R6: Interrupt mode, under-temperature direction: the same latch, read and swap behaviour as R5. The first event needs a run strictly below `lo_set`, the next strictly above `lo_clr`, and they alternate.
- R7: `stat_rd` handling:
  - In comparator mode `stat_rd` has no effect on either flag.
  - In interrupt mode, when a read and an event land on the same edge, the flag ends up set.
- R8: Shutdown:
  - While `shdn` is high, both flags are 0 from the next edge on.
  - Samples are ignored while `shdn` is high.
  - Shutdown clears both fault runs and both interrupt re-arm states.
- R9: `alarm_out` is registered and changes on the same edge as the flags. It is at its active level exactly when `ot_flag` or `ut_flag` is set. The active level is high when `alarm_pol`=1 and low when `alarm_pol`=0.
- R10: With the package default thresholds, the decision points are exact to one count:
  - A sample of 1601 sets the over flag; 1600 does not.
  - 1439 clears it; 1440 does not.
  - -641 sets the under flag; -640 does not.
  - -479 clears it; -480 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_temp | input | TEMP_W | Signed sample, 1/16 °C per count |
| hi_set | input | TEMP_W | Over-temperature set threshold |
| hi_clr | input | TEMP_W | Over-temperature hysteresis threshold |
| lo_set | input | TEMP_W | Under-temperature set threshold |
| lo_clr | input | TEMP_W | Under-temperature hysteresis threshold |
| int_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| fq_sel | input | FSW | Fault run length select, length = 2^fq_sel |
| stat_rd | input | 1 | Status-read strobe (interrupt-mode clear) |
| shdn | input | 1 | Shutdown: clear and ignore samples |
| alarm_pol | input | 1 | 1 = alarm active high, 0 = active low |
| ot_flag | output | 1 | Over-temperature status |
| ut_flag | output | 1 | Under-temperature status |
| alarm_out | output | 1 | Alarm level |

## Verification
The assertions assume the following about the inputs:
- The thresholds, `int_mode` and `fq_sel` are held steady while samples flow.
- `alarm_pol` is checked only on cycles where it did not change.

The stimulus keeps within these assumptions:
- Configuration changes only inside a shutdown pulse, which also resets every run and re-arm state, so each configuration starts from a known point.
- A triangle of temperatures sweeps across all four thresholds, with periodic neutral samples that break fault runs.
- Read strobes are interleaved in interrupt mode.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
  localparam int TEMP_W = 16;

  // Power-on threshold values, 1/16 degC per count
  localparam logic signed [TEMP_W-1:0] DEF_HI_SET = 16'sd1600;  // +100 C
  localparam logic signed [TEMP_W-1:0] DEF_HI_CLR = 16'sd1440;  // +90 C
  localparam logic signed [TEMP_W-1:0] DEF_LO_SET = -16'sd640;  // -40 C
  localparam logic signed [TEMP_W-1:0] DEF_LO_CLR = -16'sd480;  // -30 C

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_INT = 1'b1
  } alarm_mode_e;

  localparam int CH_OVER  = 0;
  localparam int CH_UNDER = 1;
  localparam int N_CH     = 2;
endpackage

// File: rtl/fault_queue.sv
module fault_queue #(
  parameter int CW  = 4,
  parameter int FSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           smp_valid,
  input  logic           hit,
  input  logic [FSW-1:0] depth_sel,
  output logic           reach
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   depth;
  logic [CW:0]   cnt_inc;

  assign depth   = (CW+1)'(1) << depth_sel;
  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
  assign reach   = !clr && smp_valid && hit && (cnt_inc >= depth);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (smp_valid) begin
      if (!hit || reach) cnt_q <= '0;
      else               cnt_q <= cnt_inc[CW-1:0];
    end
  end
endmodule

// File: rtl/alarm_track.sv
module alarm_track #(
  parameter int CW  = 4,
  parameter int FSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shdn,
  input  logic           int_mode,
  input  logic           rd,
  input  logic           smp_valid,
  input  logic           fwd_hit,
  input  logic           rev_hit,
  input  logic [FSW-1:0] depth_sel,
  output logic           flag_q,
  output logic           flag_d
);
  import temp_alarm_pkg::*;

  logic arm_q, arm_d;
  logic watch, reach;

  // In interrupt mode the armed crossing alternates after every event
  assign watch = (int_mode == MODE_INT && arm_q) ? rev_hit : fwd_hit;

  fault_queue #(.CW(CW), .FSW(FSW)) u_fq (
    .clk       (clk),
    .rst       (rst),
    .clr       (shdn || flag_q),
    .smp_valid (smp_valid),
    .hit       (watch),
    .depth_sel (depth_sel),
    .reach     (reach)
  );

  always_comb begin
    flag_d = flag_q;
    arm_d  = (int_mode == MODE_INT) ? arm_q : 1'b0;
    if (shdn) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (int_mode == MODE_CMP) begin
      if (flag_q && smp_valid && rev_hit) flag_d = 1'b0;
      else if (reach)                     flag_d = 1'b1;
    end else begin
      if (reach) begin
        flag_d = 1'b1;
        arm_d  = ~arm_q;
      end else if (rd) begin
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/temp_alarm.sv
module temp_alarm #(
  parameter int TEMP_W = 16,
  parameter int FQ_MAX = 8,
  localparam int FQ_LOG = $clog2(FQ_MAX),
  localparam int FSW    = $clog2(FQ_LOG + 1),
  localparam int CW     = FQ_LOG + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [TEMP_W-1:0] smp_temp,
  input  logic signed [TEMP_W-1:0] hi_set,
  input  logic signed [TEMP_W-1:0] hi_clr,
  input  logic signed [TEMP_W-1:0] lo_set,
  input  logic signed [TEMP_W-1:0] lo_clr,
  input  logic                     int_mode,
  input  logic [FSW-1:0]           fq_sel,
  input  logic                     stat_rd,
  input  logic                     shdn,
  input  logic                     alarm_pol,
  output logic                     ot_flag,
  output logic                     ut_flag,
  output logic                     alarm_out
);
  import temp_alarm_pkg::*;

  logic [N_CH-1:0] fwd_hit, rev_hit, flag_q, flag_d;
  logic            alarm_q;

  assign fwd_hit[CH_OVER]  = smp_temp > hi_set;
  assign rev_hit[CH_OVER]  = smp_temp < hi_clr;
  assign fwd_hit[CH_UNDER] = smp_temp < lo_set;
  assign rev_hit[CH_UNDER] = smp_temp > lo_clr;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    alarm_track #(.CW(CW), .FSW(FSW)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .shdn      (shdn),
      .int_mode  (int_mode),
      .rd        (stat_rd),
      .smp_valid (smp_valid),
      .fwd_hit   (fwd_hit[ch]),
      .rev_hit   (rev_hit[ch]),
      .depth_sel (fq_sel),
      .flag_q    (flag_q[ch]),
      .flag_d    (flag_d[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_q <= ~alarm_pol;
    else     alarm_q <= ~((|flag_d) ^ alarm_pol);
  end

  assign ot_flag   = flag_q[CH_OVER];
  assign ut_flag   = flag_q[CH_UNDER];
  assign alarm_out = alarm_q;
endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk #(
  parameter int TEMP_W = 16,
  parameter int FQ_MAX = 8,
  localparam int FSW = $clog2($clog2(FQ_MAX) + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_valid,
  input logic signed [TEMP_W-1:0] smp_temp,
  input logic signed [TEMP_W-1:0] hi_set,
  input logic                     int_mode,
  input logic [FSW-1:0]           fq_sel,
  input logic                     stat_rd,
  input logic                     shdn,
  input logic                     alarm_pol,
  input logic                     ot_flag,
  input logic                     ut_flag,
  input logic                     alarm_out
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !ot_flag && !ut_flag); // R1
  AST_OT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ot_flag) |-> $past(smp_valid)); // R2
  AST_DEPTH_ONE: assert property (@(posedge clk) disable iff (rst)
    (!int_mode && !shdn && smp_valid && fq_sel == '0 && !ot_flag && smp_temp > hi_set)
    |=> ot_flag); // R4
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (int_mode && !stat_rd && !shdn && ot_flag) |=> ot_flag); // R5
  AST_CMP_READ_INERT: assert property (@(posedge clk) disable iff (rst)
    (!int_mode && stat_rd && !shdn && !smp_valid) |=> (ot_flag == $past(ot_flag))); // R7
  AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    shdn |=> !ot_flag && !ut_flag); // R8
  AST_ALARM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $stable(alarm_pol) |-> (alarm_out == (alarm_pol ? (ot_flag || ut_flag)
                                                    : !(ot_flag || ut_flag)))); // R9
endmodule

bind temp_alarm temp_alarm_chk #(.TEMP_W(TEMP_W), .FQ_MAX(FQ_MAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_temp  (smp_temp),
  .hi_set    (hi_set),
  .int_mode  (int_mode),
  .fq_sel    (fq_sel),
  .stat_rd   (stat_rd),
  .shdn      (shdn),
  .alarm_pol (alarm_pol),
  .ot_flag   (ot_flag),
  .ut_flag   (ut_flag),
  .alarm_out (alarm_out)
);

// File: tb/temp_alarm_tb.sv
module temp_alarm_tb;
  import temp_alarm_pkg::*;

  logic clk = 0;
  logic rst = 1;
  logic smp_valid = 0;
  logic signed [15:0] smp_temp = '0;
  logic signed [15:0] th = DEF_HI_SET, thh = DEF_HI_CLR, tl = DEF_LO_SET, tlh = DEF_LO_CLR;
  logic imode = 0;
  logic [1:0] fq = 0;
  logic stat_rd = 0, shdn = 0, pol = 0;
  logic ot_flag, ut_flag, alarm_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic m_flag [2];
  logic m_arm [2];
  int   m_cnt [2];

  always #10 clk = ~clk;

  temp_alarm u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .hi_set(th), .hi_clr(thh), .lo_set(tl), .lo_clr(tlh),
    .int_mode(imode), .fq_sel(fq), .stat_rd(stat_rd), .shdn(shdn),
    .alarm_pol(pol), .ot_flag(ot_flag), .ut_flag(ut_flag), .alarm_out(alarm_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input int t, input logic rd);
    @(negedge clk);
    smp_valid = v; smp_temp = 16'(t); stat_rd = rd;
    @(negedge clk);
    smp_valid = 0; stat_rd = 0;
  endtask

  task automatic model_step(input logic v, input int t, input logic rd);
    for (int ch = 0; ch < 2; ch++) begin
      logic a, b, cond, set_now;
      a = (ch == 0) ? (t > th) : (t < tl);
      b = (ch == 0) ? (t < thh) : (t > tlh);
      set_now = 0;
      if (shdn) begin
        m_flag[ch] = 0; m_arm[ch] = 0; m_cnt[ch] = 0;
      end else begin
        if (!imode) m_arm[ch] = 0;
        if (v) begin
          if (m_flag[ch]) begin
            m_cnt[ch] = 0;
            if (!imode && b) m_flag[ch] = 0;
          end else begin
            cond = (imode && m_arm[ch]) ? b : a;
            if (cond) begin
              m_cnt[ch]++;
              if (m_cnt[ch] >= (1 << fq)) begin
                m_flag[ch] = 1; m_cnt[ch] = 0; set_now = 1;
                if (imode) m_arm[ch] = !m_arm[ch];
              end
            end else m_cnt[ch] = 0;
          end
        end
        if (imode && rd && !set_now) m_flag[ch] = 0;
      end
    end
  endtask

  task automatic mstep(input logic v, input int t, input logic rd);
    step(v, t, rd);
    model_step(v, t, rd);
  endtask

  task automatic shdn_pulse();
    shdn = 1;
    mstep(0, 0, 0);
    shdn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ot in reset", ot_flag, 0);
    chk("R1 alarm inactive in reset", alarm_out, 1);
    rst = 0;
    @(negedge clk);
    chk("R1 ut after reset", ut_flag, 0);
    chk("R1 alarm after reset", alarm_out, 1);

    // Default thresholds, comparator, depth 1, active high
    pol = 1;
    step(1, 1600, 0); chk("R10 1600 no set", ot_flag, 0);
    chk("R9 alarm idle high-pol", alarm_out, 0);
    step(1, 1601, 0); chk("R10 R2 1601 sets", ot_flag, 1);
    chk("R9 alarm active high", alarm_out, 1);
    step(1, 1440, 0); chk("R10 1440 holds", ot_flag, 1);
    step(1, 1439, 0); chk("R10 R2 1439 clears", ot_flag, 0);
    step(1, -640, 0); chk("R10 -640 no set", ut_flag, 0);
    step(1, -641, 0); chk("R10 R3 -641 sets", ut_flag, 1);
    step(1, -480, 0); chk("R10 -480 holds", ut_flag, 1);
    step(1, -479, 0); chk("R10 R3 -479 clears", ut_flag, 0);

    // Depth 4 with broken run
    fq = 2;
    repeat (3) step(1, 1700, 0);
    step(1, 0, 0);
    repeat (3) step(1, 1700, 0);
    chk("R4 broken run no set", ot_flag, 0);
    step(1, 1700, 0); chk("R4 fourth consecutive sets", ot_flag, 1);
    step(0, 0, 1); chk("R7 read inert in comparator", ot_flag, 1);
    step(1, 0, 0); chk("R2 clear below hyst", ot_flag, 0);

    // Shutdown
    fq = 0;
    step(1, 1700, 0); chk("R8 pre-shutdown set", ot_flag, 1);
    shdn = 1;
    step(0, 0, 0); chk("R8 shutdown clears", ot_flag, 0);
    step(1, 1700, 0); chk("R8 sample ignored in shutdown", ot_flag, 0);
    chk("R8 alarm idle in shutdown", alarm_out, 0);
    shdn = 0; fq = 1;
    step(1, 1700, 0); chk("R8 depth2 first", ot_flag, 0);
    shdn = 1; step(0, 0, 0); shdn = 0;
    step(1, 1700, 0); chk("R8 run cleared by shutdown", ot_flag, 0);
    step(1, 1700, 0); chk("R4 depth2 second sets", ot_flag, 1);

    // Interrupt mode, over direction
    shdn = 1; step(0, 0, 0); shdn = 0;
    imode = 1; fq = 0;
    step(1, 1700, 0); chk("R5 event sets", ot_flag, 1);
    step(1, 1700, 0); chk("R5 holds", ot_flag, 1);
    step(0, 0, 1);    chk("R5 read clears", ot_flag, 0);
    step(1, 1700, 0); chk("R5 still above no event", ot_flag, 0);
    step(1, 1439, 0); chk("R5 below hyst event", ot_flag, 1);
    step(1, 1000, 0); chk("R5 held low", ot_flag, 1);
    step(0, 0, 1);    chk("R5 read clears again", ot_flag, 0);
    step(1, 1000, 0); chk("R5 no repeat below", ot_flag, 0);
    step(1, 1601, 0); chk("R5 rise re-event", ot_flag, 1);
    step(0, 0, 1);    chk("R5 read", ot_flag, 0);
    step(1, 1000, 1); chk("R7 read and event same edge", ot_flag, 1);

    // Interrupt mode, under direction
    shdn = 1; step(0, 0, 0); shdn = 0;
    step(1, -700, 0); chk("R6 event sets", ut_flag, 1);
    step(0, 0, 1);    chk("R6 read clears", ut_flag, 0);
    step(1, -700, 0); chk("R6 still below no event", ut_flag, 0);
    step(1, -470, 0); chk("R6 above hyst event", ut_flag, 1);
    pol = 0;
    step(0, 0, 0);    chk("R9 active low alarm", alarm_out, 0);
    step(0, 0, 1);    chk("R6 read", ut_flag, 0);
    chk("R9 active low idle", alarm_out, 1);
    step(1, -650, 0); chk("R6 fall re-event", ut_flag, 1);

    // Sweep: all modes, depths and polarities
    th = 100; thh = 60; tl = -80; tlh = -40;
    for (int md = 0; md < 2; md++)
      for (int f = 0; f < 4; f++)
        for (int p = 0; p < 2; p++) begin
          shdn = 1;
          imode = md[0]; fq = f[1:0]; pol = p[0];
          mstep(0, 0, 0);
          shdn = 0;
          for (int i = 0; i < 96; i++) begin
            int ph, t;
            logic rd;
            ph = i % 48;
            t = (ph < 24) ? (-120 + ph * 12) : (-120 + (48 - ph) * 12);
            if (i % 7 == 3) t = 20;
            rd = imode && (i % 5 == 2);
            mstep(1, t, rd);
            chk("R2/R3/R4/R5/R6 sweep ot", ot_flag, m_flag[0]);
            chk("R3/R4/R6 sweep ut", ut_flag, m_flag[1]);
            chk("R9 sweep alarm", alarm_out,
                pol ? (m_flag[0] | m_flag[1]) : !(m_flag[0] | m_flag[1]));
          end
        end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule